// File: doc/BRIEF.md
# Interrupt Enable Gating Unit

This block owns the global interrupt enable bit of a 16-bit CPU status register. At each instruction boundary it decides whether a pending maskable interrupt request is taken. The pipeline supplies a retire strobe for each completed instruction and, for that instruction, decoded flags for an enable operation, a disable operation or a full status-register load. The block returns the current status register and a one-cycle accept pulse.

Changes to the enable bit reach the acceptance logic one instruction late. An internal effective-enable register copies the enable bit only on a retire strobe, and it copies the value the bit had before the retiring instruction changed it. As a result, the instruction after an enable always runs before any interrupt is taken. The boundary directly after a disable can still take an interrupt. When an enable is directly followed by a disable, the result is fixed: nothing is accepted at the boundary between the two, and a request that is still pending is accepted at the boundary after the disable.

There is no data stream at this block's edge. All pins are plain control and status signals, with no valid/ready handshake.

Top module: `irq_gate_top`

## Requirements
- R1: A synchronous active-high reset clears the whole status register to 0x0000 and holds the accept output low.
- R2: An enable operation with retire high ORs the status register with 0x0008 (the enable flag is bit 3) and changes no other bit.
- R3: A disable operation with retire high ANDs the status register with 0xFFF7. The flag bits 0-2 and 8 and the mode bits 4-5 stay as they were.
- R4: A load operation with retire high writes all 16 bits of write data into the status register. If several operation flags are high together, the load wins over the disable, and the disable wins over the enable.
- R5: While retire is low, the operation flags and the write data have no effect on the status register.
- R6: The accept output is high only in the cycle directly after a retire strobe. In that cycle it is high when the request line is high and the enable bit was 1 before that retired instruction updated it.
- R7: After the retire of an instruction that sets the enable bit from 0, no interrupt is accepted in the next cycle, even with a request pending. The next instruction must retire first.
- R8: A disable does not protect the boundary directly after it. If the enable bit was 1, a pending request is accepted in the cycle after the disable retires. From the following boundary on, no request is accepted.
- R9: When an enable retires directly followed by a disable, no interrupt is accepted at the boundary between them. A request still pending is accepted in the cycle after the disable retires.
- R10: A load operation that sets and then clears the enable bit follows the same timing as the dedicated enable and disable operations.
- R11: The accept pulse lasts exactly one cycle. At the end of that cycle, enable bit 3 is cleared. This happens after any update from an instruction retiring in the same cycle.
- R12: With no retire strobe in the preceding cycle, no interrupt is accepted, even with the enable bit set and a request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire_i | input | 1 | One instruction retires this cycle |
| set_en_i | input | 1 | Retiring instruction is an enable operation |
| clr_en_i | input | 1 | Retiring instruction is a disable operation |
| sr_wr_i | input | 1 | Retiring instruction loads the status register |
| sr_wdata_i | input | 16 | Load data for the status register |
| irq_pend_i | input | 1 | Maskable interrupt request pending |
| sr_o | output | 16 | Current status register |
| irq_accept_o | output | 1 | Interrupt accepted at this boundary (one cycle) |

## Verification
Two functions can fall in the same cycle: an interrupt acceptance and the retire of a further instruction that writes the status register. The bench provokes this by retiring an enable operation, and separately a full load that sets bit 3, in the very cycle the accept pulse is high. The scoreboard expects the retired update to land and then bit 3 to read 0 in the next cycle. It also expects no second accept, even with the request still high and another retire following.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int SR_WIDTH = 16;
  localparam int GIE_POS  = 3;

  typedef enum logic [1:0] {
    SR_OP_NONE,
    SR_OP_SET,
    SR_OP_CLR,
    SR_OP_LOAD
  } sr_op_e;
endpackage

// File: rtl/irq_sr_op_sel.sv
module irq_sr_op_sel
  import irq_gate_pkg::*;
(
  input  logic   retire_i,
  input  logic   set_en_i,
  input  logic   clr_en_i,
  input  logic   sr_wr_i,
  output sr_op_e op_o
);
  // Priority: full load, then clear, then set; nothing without retire.
  always_comb begin
    op_o = SR_OP_NONE;
    if (retire_i) begin
      if (sr_wr_i)       op_o = SR_OP_LOAD;
      else if (clr_en_i) op_o = SR_OP_CLR;
      else if (set_en_i) op_o = SR_OP_SET;
    end
  end
endmodule

// File: rtl/irq_sr_next.sv
module irq_sr_next
  import irq_gate_pkg::*;
#(
  parameter int W   = SR_WIDTH,
  parameter int GIE = GIE_POS
) (
  input  sr_op_e       op_i,
  input  logic [W-1:0] sr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         accept_i,
  output logic [W-1:0] sr_next_o
);
  localparam logic [W-1:0] GIE_MASK = W'(1) << GIE;

  logic [W-1:0] after_op;

  always_comb begin
    unique case (op_i)
      SR_OP_SET:  after_op = sr_i | GIE_MASK;
      SR_OP_CLR:  after_op = sr_i & ~GIE_MASK;
      SR_OP_LOAD: after_op = wdata_i;
      default:    after_op = sr_i;
    endcase
    // An accepted interrupt clears the enable last.
    sr_next_o = accept_i ? (after_op & ~GIE_MASK) : after_op;
  end
endmodule

// File: rtl/irq_eff_track.sv
module irq_eff_track (
  input  logic clk,
  input  logic rst,
  input  logic retire_i,
  input  logic gie_now_i,
  input  logic pend_i,
  output logic accept_o
);
  logic eff_q;
  logic bnd_q;

  assign accept_o = bnd_q & eff_q & pend_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q <= 1'b0;
      bnd_q <= 1'b0;
    end else begin
      bnd_q <= retire_i;
      if (accept_o)      eff_q <= 1'b0;
      else if (retire_i) eff_q <= gie_now_i;
    end
  end

  // R11
  acc_single_chk: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> !accept_o);

  // R6
  acc_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> pend_i);

  // R7
  acc_late_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !gie_now_i) |=> !accept_o);

  // R12
  acc_after_retire_chk: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> $past(retire_i));
endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
  import irq_gate_pkg::*;
#(
  parameter int W   = SR_WIDTH,
  parameter int GIE = GIE_POS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         retire_i,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic         sr_wr_i,
  input  logic [W-1:0] sr_wdata_i,
  input  logic         irq_pend_i,
  output logic [W-1:0] sr_o,
  output logic         irq_accept_o
);
  localparam logic [W-1:0] GIE_MASK = W'(1) << GIE;

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;
  sr_op_e       op;

  irq_sr_op_sel u_sel (
    .retire_i (retire_i),
    .set_en_i (set_en_i),
    .clr_en_i (clr_en_i),
    .sr_wr_i  (sr_wr_i),
    .op_o     (op)
  );

  irq_sr_next #(.W(W), .GIE(GIE)) u_next (
    .op_i      (op),
    .sr_i      (sr_q),
    .wdata_i   (sr_wdata_i),
    .accept_i  (irq_accept_o),
    .sr_next_o (sr_d)
  );

  irq_eff_track u_eff (
    .clk       (clk),
    .rst       (rst),
    .retire_i  (retire_i),
    .gie_now_i (sr_q[GIE]),
    .pend_i    (irq_pend_i),
    .accept_o  (irq_accept_o)
  );

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_d;
  end

  assign sr_o = sr_q;

  // R5
  sr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!retire_i && !irq_accept_o) |=> $stable(sr_o));

  // R11
  acc_clears_gie_chk: assert property (@(posedge clk) disable iff (rst)
    irq_accept_o |=> !sr_o[GIE]);

  // R2
  set_only_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && set_en_i && !clr_en_i && !sr_wr_i && !irq_accept_o)
      |=> sr_o == ($past(sr_o) | GIE_MASK));

  // R3
  clr_only_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && clr_en_i && !sr_wr_i)
      |=> sr_o == ($past(sr_o) & ~GIE_MASK));
endmodule

// File: tb/test_irq_gate_top.sv
module test_irq_gate_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire_i = 1'b0;
  logic        set_en_i = 1'b0;
  logic        clr_en_i = 1'b0;
  logic        sr_wr_i = 1'b0;
  logic [15:0] sr_wdata_i = '0;
  logic        irq_pend_i = 1'b0;
  logic [15:0] sr_o;
  logic        irq_accept_o;

  always #2 clk = ~clk;

  irq_gate_top i_irq_gate_top (
    .clk          (clk),
    .rst          (rst),
    .retire_i     (retire_i),
    .set_en_i     (set_en_i),
    .clr_en_i     (clr_en_i),
    .sr_wr_i      (sr_wr_i),
    .sr_wdata_i   (sr_wdata_i),
    .irq_pend_i   (irq_pend_i),
    .sr_o         (sr_o),
    .irq_accept_o (irq_accept_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] q_sr[$];
  logic        q_acc[$];
  string       q_tag[$];

  // Reference model state
  logic [15:0] m_sr  = '0;
  logic        m_eff = 1'b0;
  logic        m_bnd = 1'b0;

  task automatic drv(input logic r, input logic s, input logic c, input logic w,
                     input logic [15:0] d, input logic p, input string tag);
    logic [15:0] nsr;
    logic        acc;
    logic        neff;
    @(negedge clk);
    retire_i = r; set_en_i = s; clr_en_i = c; sr_wr_i = w;
    sr_wdata_i = d; irq_pend_i = p;
    acc = m_bnd & m_eff & p;
    q_sr.push_back(m_sr); q_acc.push_back(acc); q_tag.push_back(tag);
    nsr = m_sr;
    neff = m_eff;
    if (r) begin
      if (w)      nsr = d;
      else if (c) nsr = m_sr & 16'hFFF7;
      else if (s) nsr = m_sr | 16'h0008;
      neff = m_sr[3];
    end
    if (acc) begin
      nsr[3] = 1'b0;
      neff = 1'b0;
    end
    m_sr = nsr; m_eff = neff; m_bnd = r;
  endtask

  task automatic idle(input logic p, input string tag);
    drv(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, p, tag);
  endtask
  task automatic ei(input logic p, input string tag);
    drv(1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, p, tag);
  endtask
  task automatic di(input logic p, input string tag);
    drv(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, p, tag);
  endtask
  task automatic nop(input logic p, input string tag);
    drv(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, p, tag);
  endtask
  task automatic ld(input logic [15:0] d, input logic p, input string tag);
    drv(1'b1, 1'b0, 1'b0, 1'b1, d, p, tag);
  endtask

  // Monitor: pops one expectation per cycle, samples after the driver settles
  always @(negedge clk) begin
    #1;
    if (q_sr.size() > 0) begin
      logic [15:0] esr;
      logic        eacc;
      string       t;
      esr = q_sr.pop_front(); eacc = q_acc.pop_front(); t = q_tag.pop_front();
      n_vec++;
      if (sr_o !== esr || irq_accept_o !== eacc) begin
        n_bad++;
        $display("FAIL %s: sr=%h acc=%b expected sr=%h acc=%b", t, sr_o, irq_accept_o, esr, eacc);
      end
    end
  end

  bit finished = 0;

  initial begin
    #40000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    idle(1'b0, "R1");
    idle(1'b1, "R1");
    // R2 enable touches only bit 3
    ld(16'h0137, 1'b0, "R4");
    ei(1'b0, "R2");
    idle(1'b0, "R2");
    // R3 disable leaves flags and mode bits
    ld(16'hFFFF, 1'b0, "R4");
    di(1'b0, "R3");
    idle(1'b0, "R3");
    ld(16'h0000, 1'b0, "R4");
    idle(1'b0, "R4");
    // R5 flags without retire are ignored
    drv(1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, "R5");
    drv(1'b0, 1'b0, 1'b0, 1'b1, 16'hBEEF, 1'b0, "R5");
    idle(1'b0, "R5");
    // R4 priority: load beats clear and set; clear beats set
    drv(1'b1, 1'b1, 1'b1, 1'b1, 16'h00A8, 1'b0, "R4");
    drv(1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, "R4");
    idle(1'b0, "R4");
    idle(1'b0, "R4");
    // R7 / R6: request held across enable
    ei(1'b1, "R7");
    nop(1'b1, "R7");
    idle(1'b1, "R6");
    idle(1'b1, "R11");
    idle(1'b1, "R11");
    // R8: disable does not protect the next boundary
    ei(1'b0, "R8");
    nop(1'b0, "R8");
    di(1'b0, "R8");
    idle(1'b1, "R8");
    idle(1'b1, "R8");
    ei(1'b0, "R8");
    nop(1'b0, "R8");
    di(1'b0, "R8");
    nop(1'b0, "R8");
    idle(1'b1, "R8");
    idle(1'b1, "R8");
    // R9: enable directly followed by disable
    ei(1'b1, "R9");
    di(1'b1, "R9");
    idle(1'b1, "R9");
    idle(1'b1, "R9");
    // R10: load sets then clears the enable
    ld(16'h0008, 1'b1, "R10");
    ld(16'h0000, 1'b1, "R10");
    idle(1'b1, "R10");
    idle(1'b1, "R10");
    // R11: retire of an enable in the accept cycle
    ei(1'b0, "R11");
    nop(1'b0, "R11");
    ei(1'b1, "R11");
    nop(1'b1, "R11");
    nop(1'b1, "R11");
    idle(1'b1, "R11");
    // R11: load setting bit 3 in the accept cycle
    ei(1'b0, "R11");
    nop(1'b0, "R11");
    ld(16'h0F0F, 1'b1, "R11");
    idle(1'b1, "R11");
    idle(1'b0, "R11");
    // R12: no boundary, no acceptance
    ei(1'b0, "R12");
    nop(1'b0, "R12");
    idle(1'b0, "R12");
    idle(1'b1, "R12");
    idle(1'b1, "R12");
    nop(1'b1, "R12");
    idle(1'b1, "R12");
    idle(1'b0, "R12");
    repeat (2) @(negedge clk);
    #2;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule